// File: doc/BRIEF.md
# Pulse-Spread 14-bit PWM Converter

This block turns a 14-bit duty value into a PWM waveform meant for a plain RC low-pass filter. The high time is not issued as one wide pulse. Each conversion period is cut into 64 equal slots, and every slot starts with a short high pulse. This pushes the ripple energy up to 64 times the period rate, so a cheap filter can smooth it.

Software writes the duty value over a narrow register port in two steps. First it writes the low byte, then the upper 6 bits. The upper write commits the full value as pending data. The generator adopts pending data only at a period boundary. Both registers are write-only, and a read always returns all ones.

A plain `clk_sel` pin picks the generator tick. The tick is one system clock or two system clocks. A period is always 16384 ticks. An `out_en` pin gates the output. There is no stream traffic at this block's edge. Register writes are accepted on every cycle and there is no back-pressure.

Top module: `pwm14_spread`

## Requirements
- R1: A write with `bus_addr`=0 stores `wr_data` as the low byte. By itself this write never changes the waveform.
- R2: A write with `bus_addr`=1 forms pending data as {`wr_data[5:0]`, stored low byte}. Bits 7:6 of that write are ignored.
- R3: `rd_data` is 8'hFF at either address, at all times.
- R4: After reset the active data is 0, so each period holds 64 high ticks in total.
- R5: When `clk_sel`=0 one tick lasts 1 system clock. When `clk_sel`=1 one tick lasts 2 system clocks. A period lasts 16384 ticks.
- R6: The total high time per period is (data + 64) ticks, as long as no slot saturates.
- R7: Slot i (0..63) is high for its first B or B+1 ticks, where B = floor((data+64)/64). The extra tick goes to slot i exactly when bit-reverse(i) < data[5:0]. For data[5:0]=32 the even slots get the extra tick, so pulse widths alternate between B+1 and B.
- R8: Pending data becomes active only at the first tick of a new period, or on a clock-select restart (R11).
- R9: When a slot's computed width reaches 256 ticks, the output stays high for the whole slot. With data 16383 the output is high through the entire period.
- R10: While `out_en` is 0, `pwm_out` is 0 from the next clock onward.
- R11: A change of `clk_sel` restarts the period at tick 0 of slot 0 on the next clock. The same restart loads the pending data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the low byte, 1 selects the upper part |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, always all ones |
| clk_sel | input | 1 | Tick select: 0 means 1 clock per tick, 1 means 2 clocks per tick |
| out_en | input | 1 | Output enable |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that `clk_sel`, `out_en` and the write port hold steady values from the first clock edge. They also assume that `clk_sel` changes only between clock edges, so that the restart check sees a clean change. The stimulus drives every input on the falling edge and gives each one a defined value before reset is released. Duty measurements use windows of exactly one period, so their totals do not depend on phase. Each window starts only after a full period has passed since the last commit, so no window spans old and new data. The one deliberate exception is the restart test, which checks that data loads at once.

// File: rtl/pwm14_pkg.sv
package pwm14_pkg;
  localparam int unsigned BUS_W        = 8;
  localparam int unsigned DEF_SUB_BITS  = 6;
  localparam int unsigned DEF_SLOT_BITS = 8;
endpackage

// File: rtl/pwm14_regs.sv
module pwm14_regs
  import pwm14_pkg::*;
#(
  parameter int unsigned DW = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             load,
  output logic [DW-1:0]    pending,
  output logic [DW-1:0]    active
);
  localparam int unsigned HI_W = DW - BUS_W;

  logic [BUS_W-1:0] low_q;
  logic             unused_hi_bits;

  assign unused_hi_bits = ^wr_data[BUS_W-1:HI_W];

  // staging: the low byte waits for the upper write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q   <= '0;
      pending <= '0;
    end else if (wr_en) begin
      if (!bus_addr) low_q   <= wr_data;
      else           pending <= {wr_data[HI_W-1:0], low_q};
    end
  end

  // active copy changes only at a period boundary
  always_ff @(posedge clk) begin
    if (!rst_n)    active <= '0;
    else if (load) active <= pending;
  end
endmodule

// File: rtl/pwm14_timebase.sv
module pwm14_timebase #(
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_sel,
  output logic          sel_q,
  output logic          tick,
  output logic          load,
  output logic [CW-1:0] cnt
);
  logic phase_q;
  logic restart;

  assign restart = (clk_sel != sel_q);
  assign tick    = sel_q ? phase_q : 1'b1;
  assign load    = restart || (tick && (cnt == '1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      phase_q <= 1'b0;
      cnt     <= '0;
    end else if (restart) begin
      sel_q   <= clk_sel;
      phase_q <= 1'b0;
      cnt     <= '0;
    end else begin
      if (sel_q) phase_q <= ~phase_q;
      if (tick)  cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm14_shaper.sv
module pwm14_shaper #(
  parameter int unsigned SUB_BITS  = 6,
  parameter int unsigned SLOT_BITS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          out_en,
  input  logic [SUB_BITS+SLOT_BITS-1:0] active,
  input  logic [SUB_BITS+SLOT_BITS-1:0] cnt,
  output logic                          pwm_out
);
  localparam int unsigned DW = SUB_BITS + SLOT_BITS;

  logic [SUB_BITS-1:0]  slot_idx;
  logic [SUB_BITS-1:0]  slot_rev;
  logic [SLOT_BITS-1:0] pos;
  logic [DW:0]          sum;
  logic [SLOT_BITS:0]   base;
  logic                 extra;
  logic [SLOT_BITS:0]   width;
  logic                 sat;
  logic                 hi_d;

  assign slot_idx = cnt[DW-1:SLOT_BITS];
  assign pos      = cnt[SLOT_BITS-1:0];

  for (genvar g = 0; g < SUB_BITS; g++) begin : g_rev
    assign slot_rev[g] = slot_idx[SUB_BITS-1-g];
  end

  assign sum   = {1'b0, active} + (DW+1)'(1 << SUB_BITS);
  assign base  = sum[DW:SUB_BITS];
  assign extra = (slot_rev < active[SUB_BITS-1:0]);
  assign width = base + {{SLOT_BITS{1'b0}}, extra};
  assign sat   = width[SLOT_BITS];
  assign hi_d  = out_en && (sat || (pos < width[SLOT_BITS-1:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= hi_d;
  end
endmodule

// File: rtl/pwm14_spread.sv
module pwm14_spread
  import pwm14_pkg::*;
#(
  parameter int unsigned SUB_BITS  = DEF_SUB_BITS,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  input  logic             clk_sel,
  input  logic             out_en,
  output logic             pwm_out
);
  localparam int unsigned DW = SUB_BITS + SLOT_BITS;

  logic [DW-1:0] pending;
  logic [DW-1:0] active;
  logic [DW-1:0] cnt;
  logic          load;
  logic          tick;
  logic          sel_q;

  assign rd_data = '1;

  pwm14_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
    .wr_data(wr_data), .load(load), .pending(pending), .active(active)
  );

  pwm14_timebase #(.CW(DW)) u_tb (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .sel_q(sel_q),
    .tick(tick), .load(load), .cnt(cnt)
  );

  pwm14_shaper #(.SUB_BITS(SUB_BITS), .SLOT_BITS(SLOT_BITS)) u_shp (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .active(active),
    .cnt(cnt), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm14_spread_chk.sv
module pwm14_spread_chk #(
  parameter int unsigned DW        = 14,
  parameter int unsigned SLOT_BITS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          bus_addr,
  input logic          clk_sel,
  input logic          out_en,
  input logic          pwm_out,
  input logic          sel_q,
  input logic          tick,
  input logic          load,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] pending,
  input logic [DW-1:0] active
);
  localparam int unsigned SUB_BITS = DW - SLOT_BITS;
  localparam logic [DW-1:0] FULL_AT = DW'((1 << DW) - (1 << SUB_BITS));

  assert_low_write_no_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_addr) |=> $stable(pending));

  assert_half_rate_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel_q && (clk_sel == sel_q)) |=> !tick);

  assert_adopt_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> $past(load));

  assert_full_slot_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && (active >= FULL_AT)) |=> pwm_out);

  assert_gate_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !pwm_out);

  assert_restart_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != sel_q) |=> (cnt == '0) && (active == $past(pending)));
endmodule

bind pwm14_spread pwm14_spread_chk #(.DW(SUB_BITS + SLOT_BITS), .SLOT_BITS(SLOT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
  .clk_sel(clk_sel), .out_en(out_en), .pwm_out(pwm_out), .sel_q(sel_q),
  .tick(tick), .load(load), .cnt(cnt), .pending(pending), .active(active)
);

// File: tb/pwm14_spread_tb_top.sv
module pwm14_spread_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_sel = 1'b0;
  logic       out_en = 1'b1;
  logic       pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int hi_total, runs_a, runs_b, runs_other, same_adjacent;

  always #5 clk = ~clk;

  pwm14_spread dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
    .wr_data(wr_data), .rd_data(rd_data), .clk_sel(clk_sel),
    .out_en(out_en), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; bus_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // count high cycles and the lengths of complete high runs over n cycles
  task automatic measure(input int n, input int len_a, input int len_b);
    int  run = 0;
    int  prev = -1;
    bit  seen_low = 1'b0;
    hi_total = 0; runs_a = 0; runs_b = 0; runs_other = 0; same_adjacent = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) begin
        hi_total++;
        run++;
      end else begin
        if (seen_low && run > 0) begin
          if (run == len_a) runs_a++;
          else if (run == len_b) runs_b++;
          else runs_other++;
          if (run == prev) same_adjacent++;
          prev = run;
        end
        run = 0;
        seen_low = 1'b1;
      end
    end
  endtask

  task automatic t_reset_and_low_only;
    bus_addr = 1'b0; #1;
    check("R3 read low", int'(rd_data), 255);
    bus_addr = 1'b1; #1;
    check("R3 read high", int'(rd_data), 255);
    write_reg(1'b0, 8'hE0);          // R1: low byte alone
    measure(16384, 1, 2);
    check("R4/R1 reset high total", hi_total, 64);
  endtask

  task automatic t_spread;
    write_reg(1'b1, 8'h03);          // R2: data = 0x3E0 = 992, base 16, rem 32
    bus_addr = 1'b0; #1;
    check("R3 read after write", int'(rd_data), 255);
    repeat (16400) @(negedge clk);   // R8: wait for adoption
    measure(16384, 17, 16);
    check("R6 total 992+64", hi_total, 1056);
    check("R7 odd widths", runs_other, 0);
    check("R7 alternation", same_adjacent, 0);
    check("R7 wide pulses seen", int'(runs_a >= 31), 1);
  endtask

  task automatic t_saturate;
    write_reg(1'b0, 8'hFF);
    write_reg(1'b1, 8'hFF);          // R2: bits 7:6 ignored -> 16383
    repeat (16400) @(negedge clk);
    measure(16384, 1, 2);
    check("R9 full period high", hi_total, 16384);
  endtask

  task automatic t_slow_tick;
    write_reg(1'b0, 8'd100);
    write_reg(1'b1, 8'h00);          // data 100: base 2, rem 36
    @(negedge clk); clk_sel = 1'b1;  // R11: restart loads pending
    repeat (100) @(negedge clk);
    measure(32768, 4, 6);
    check("R5/R11 total 2*(100+64)", hi_total, 328);
    check("R5 widths doubled", runs_other, 0);
  endtask

  task automatic t_disable;
    @(negedge clk); out_en = 1'b0;
    @(negedge clk);
    measure(1000, 4, 6);
    check("R10 gated output", hi_total, 0);
    bus_addr = 1'b1; #1;
    check("R3 read late", int'(rd_data), 255);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_low_only();
    t_spread();
    t_saturate();
    t_slow_tick();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule